// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM with a pipelined read path and a four-beat burst engine. The data path is split into byte lanes (four lanes of nine bits by default), and the depth is a parameter (256 words by default). Every control, address and data input is captured on the rising clock edge. Read data leaves through an output register, and the pad drive is qualified by an asynchronous output enable.

Two active-low address strobes start an access. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write qualifiers. Once an address is loaded, an active-low advance input steps a two-bit beat counter. The counter rewrites only the two low address bits, in linear or interleaved order, and the order is chosen by a mode pin when the address is loaded. A global write stores all lanes. Otherwise a byte-write enable, together with per-lane strobes, picks the lanes to store.

The data bus is modelled as a separate input and output plus a drive flag. A low drive flag means the pad is at high impedance, and the output bits are then held at zero.

Top module: `sram_burst_pipe`

## Requirements
- R1: On a rising edge where either strobe (ads_proc_n or ads_ctrl_n) is low and ce_n is low, the address is loaded and the beat count restarts at zero, so that cycle accesses exactly the presented address.
- R2: A cycle that loads through ads_proc_n is always a read. The write qualifiers and dq_in in that cycle leave memory unchanged.
- R3: With no strobe low, adv_n low advances the beat count by one. With adv_n high, the access repeats the current address.
- R4: With order_ilv low at load, beat n uses low address bits (base + n) mod 4. The upper address bits stay as loaded, and the fifth beat returns to the loaded address.
- R5: With order_ilv high at load, beat n uses low address bits base XOR n.
- R6: wr_global_n low, in an active cycle not loaded by ads_proc_n, writes all lanes with the dq_in captured on that edge, whatever the lane strobes are.
- R7: With wr_global_n high and byte_wr_en_n low, exactly the lanes i whose lane_wr_n[i] is low are written; lane i is dq bits [9i+8:9i]. With both high, the cycle is a read.
- R8: Read data for an access captured on edge k is on dq_out, with dq_drv high, from edge k+1 until edge k+2. A burst gives one word per cycle.
- R9: oe_n high forces dq_drv low at once, with no clock edge, and oe_n low restores it.
- R10: A strobe with ce_n high deselects. That cycle and the following advance or idle cycles are inactive, and dq_drv is low after the next edge.
- R11: After reset the block is deselected and dq_drv is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| ce_n | input | 1 | Active-low chip enable, sampled with a strobe |
| ads_proc_n | input | 1 | Active-low processor-side address strobe (read) |
| ads_ctrl_n | input | 1 | Active-low controller-side address strobe |
| adv_n | input | 1 | Active-low burst advance |
| order_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wr_global_n | input | 1 | Active-low write of all lanes |
| byte_wr_en_n | input | 1 | Active-low enable for the lane strobes |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, zero while not driving |
| dq_drv | output | 1 | Pad drive flag, low means high impedance |

## Verification
An access captured on one edge produces its read word after the following edge, so the bench checks the result of each command one full command later. It drives every command on a falling edge and compares the previous command's expected word and drive flag at the next falling edge. The only result not tied to the clock is the output-enable response, which the bench checks a fraction of a cycle after toggling oe_n, well before the next rising edge. Deselect and write cycles must show the drive flag low in that same one-command-late slot.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

   // beat address for a four-beat burst
   function automatic logic [1:0] beat_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
      logic [1:0] r;
      if (ilv) r = base ^ cnt;
      else     r = base + cnt;
      return r;
   endfunction

   // burst order choice fixed at elaboration
   localparam int ORD_PIN    = 0;
   localparam int ORD_LINEAR = 1;
   localparam int ORD_ILV    = 2;

endpackage

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
   import sram_burst_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int LANES      = 4,
   parameter int ORDER_MODE = ORD_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              ads_proc_n,
   input  logic              ads_ctrl_n,
   input  logic              adv_n,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_global_n,
   input  logic              byte_wr_en_n,
   input  logic [LANES-1:0]  lane_wr_n,
   output logic              op_act,
   output logic              op_wr,
   output logic [LANES-1:0]  op_mask,
   output logic [ADDR_W-1:0] op_addr
);

   localparam int UP_W = ADDR_W - 2;

   logic            sel_q, ilv_q, act_q, wr_q;
   logic [UP_W-1:0] upper_q;
   logic [1:0]      base_q, cnt_q;
   logic [LANES-1:0] mask_q;

   logic strobe, load, desel, ilv_src, next_act, next_wr;
   logic [LANES-1:0] lane_sel;

   generate
      if (ORDER_MODE == ORD_PIN) begin : g_ord_pin
         assign ilv_src = order_ilv;
      end else if (ORDER_MODE == ORD_LINEAR) begin : g_ord_lin
         assign ilv_src = 1'b0;
      end else begin : g_ord_ilv
         assign ilv_src = 1'b1;
      end
   endgenerate

   always_comb begin
      strobe   = !ads_proc_n || !ads_ctrl_n;
      load     = strobe && !ce_n;
      desel    = strobe && ce_n;
      if (!wr_global_n)       lane_sel = '1;
      else if (!byte_wr_en_n) lane_sel = ~lane_wr_n;
      else                    lane_sel = '0;
      next_act = strobe ? !ce_n : sel_q;
      next_wr  = next_act && ads_proc_n && (lane_sel != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         ilv_q   <= 1'b0;
         upper_q <= '0;
         base_q  <= '0;
         cnt_q   <= '0;
         act_q   <= 1'b0;
         wr_q    <= 1'b0;
         mask_q  <= '0;
      end else begin
         if (load) begin
            sel_q   <= 1'b1;
            ilv_q   <= ilv_src;
            upper_q <= addr[ADDR_W-1:2];
            base_q  <= addr[1:0];
            cnt_q   <= '0;
         end else if (desel) begin
            sel_q <= 1'b0;
         end else if (!adv_n && sel_q) begin
            cnt_q <= cnt_q + 2'd1;
         end
         act_q  <= next_act;
         wr_q   <= next_wr;
         mask_q <= next_wr ? lane_sel : '0;
      end
   end

   assign op_act  = act_q;
   assign op_wr   = wr_q;
   assign op_mask = mask_q;
   assign op_addr = {upper_q, beat_low(base_q, cnt_q, ilv_q)};

   // R3: counter holds when neither a strobe nor advance is asserted
   a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ads_proc_n && ads_ctrl_n && adv_n) |=> $stable(cnt_q));

   // R4: upper address bits change only on a load
   a_r4_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load) |=> $stable(upper_q));

   // R2: processor-strobe load is a read
   a_r2_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_proc_n && !ce_n) |=> (act_q && !wr_q));

   // R6: global write covers all lanes
   a_r6_global_all: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_ctrl_n && ads_proc_n && !ce_n && !wr_global_n) |=> (wr_q && mask_q == '1));

   // R7: byte-write lanes follow the lane strobes
   a_r7_lane_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_ctrl_n && ads_proc_n && !ce_n && wr_global_n && !byte_wr_en_n && lane_wr_n != '1)
      |=> (mask_q == ~$past(lane_wr_n)));

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] din,
   output logic [LANE_W-1:0] rd_data
);

   logic [LANE_W-1:0] mem [DEPTH];
   logic [LANE_W-1:0] din_q;
   logic [LANE_W-1:0] q;

   // write data captured with its command, stored one edge later
   always_ff @(posedge clk) begin
      din_q <= din;
      if (wr_en) mem[addr] <= din_q;
      if (rd_en) q <= mem[addr];
   end

   assign rd_data = q;

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drv
);

   logic vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= rd_fire;
   end

   // output enable acts without a clock
   always_comb begin
      dq_drv = vld_q && !oe_n;
      dq_out = dq_drv ? rd_data : '0;
   end

endmodule

// File: rtl/sram_burst_pipe.sv
module sram_burst_pipe
   import sram_burst_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int LANES      = 4,
   parameter int DATA_W     = 36,
   parameter int ORDER_MODE = ORD_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              ads_proc_n,
   input  logic              ads_ctrl_n,
   input  logic              adv_n,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_global_n,
   input  logic              byte_wr_en_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drv
);

   localparam int LANE_W = DATA_W / LANES;
   localparam int DEPTH  = 1 << ADDR_W;

   generate
      if (DATA_W % LANES != 0) begin : g_bad_lanes
         $error("DATA_W must split evenly into LANES");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must exceed the two burst bits");
      end
      if (ORDER_MODE < ORD_PIN || ORDER_MODE > ORD_ILV) begin : g_bad_ord
         $error("ORDER_MODE out of range");
      end
   endgenerate

   logic              op_act, op_wr, rd_fire;
   logic [LANES-1:0]  op_mask;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] rd_word;

   sram_burst_ctl #(
      .ADDR_W(ADDR_W), .LANES(LANES), .ORDER_MODE(ORDER_MODE)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n),
      .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
      .order_ilv(order_ilv), .addr(addr), .wr_global_n(wr_global_n),
      .byte_wr_en_n(byte_wr_en_n), .lane_wr_n(lane_wr_n),
      .op_act(op_act), .op_wr(op_wr), .op_mask(op_mask), .op_addr(op_addr)
   );

   assign rd_fire = op_act && !op_wr;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         sram_byte_lane #(
            .ADDR_W(ADDR_W), .LANE_W(LANE_W), .DEPTH(DEPTH)
         ) u_lane (
            .clk(clk),
            .wr_en(op_act && op_wr && op_mask[i]),
            .rd_en(rd_fire),
            .addr(op_addr),
            .din(dq_in[i*LANE_W +: LANE_W]),
            .rd_data(rd_word[i*LANE_W +: LANE_W])
         );
      end
   endgenerate

   sram_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_data(rd_word),
      .oe_n(oe_n), .dq_out(dq_out), .dq_drv(dq_drv)
   );

   // R10: an inactive cycle leaves the pad undriven after the output stage
   a_r10_desel_float: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_act) |=> !dq_drv);

   // R8: a read access drives the pad one edge later unless oe_n blocks it
   a_r8_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (op_act && !op_wr) |=> (oe_n || dq_drv));

endmodule

// File: tb/sim_sram_burst_pipe.sv
module sim_sram_burst_pipe;

   localparam int AW = 8;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
   logic          order_ilv = 1'b0, wr_global_n = 1'b1, byte_wr_en_n = 1'b1, oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [3:0]    lane_wr_n = 4'hF;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_drv;

   always #2 clk = ~clk;

   sram_burst_pipe u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ads_proc_n(ads_proc_n),
      .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .order_ilv(order_ilv), .addr(addr),
      .wr_global_n(wr_global_n), .byte_wr_en_n(byte_wr_en_n), .lane_wr_n(lane_wr_n),
      .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_drv(dq_drv)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state
   logic [DW-1:0] mdl [256];
   logic       m_sel = 1'b0, m_ilv = 1'b0;
   logic [5:0] m_up = '0;
   logic [1:0] m_base = '0, m_cnt = '0;

   logic          p_drv = 1'b0;
   logic [DW-1:0] p_data = '0;
   string         p_tag = "R11";

   localparam int K_P = 0, K_C = 1, K_A = 2, K_S = 3;

   function automatic logic [DW-1:0] pat(input int a);
      logic [DW-1:0] v;
      v = DW'(a) * 36'd1234567;
      return v ^ 36'h9_3C5A_A5C3;
   endfunction

   task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual drv/data=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input int kind, input logic cen, input int a, input logic gw,
                        input logic bwe, input logic [3:0] lw, input logic [DW-1:0] d,
                        input logic ilv, input string tag);
      logic act, wr;
      logic [3:0] msk;
      logic [7:0] ea;
      ads_proc_n   = (kind == K_P) ? 1'b0 : 1'b1;
      ads_ctrl_n   = (kind == K_C) ? 1'b0 : 1'b1;
      adv_n        = (kind == K_A) ? 1'b0 : 1'b1;
      ce_n         = cen;
      addr         = AW'(a);
      wr_global_n  = gw;
      byte_wr_en_n = bwe;
      lane_wr_n    = lw;
      dq_in        = d;
      order_ilv    = ilv;
      // reference update
      if (kind == K_P || kind == K_C) begin
         if (cen) begin
            m_sel = 1'b0;
            act = 1'b0;
         end else begin
            m_sel = 1'b1; m_ilv = ilv; m_up = 6'(a >> 2); m_base = 2'(a); m_cnt = 2'd0;
            act = 1'b1;
         end
      end else begin
         if (kind == K_A && m_sel) m_cnt = m_cnt + 2'd1;
         act = m_sel;
      end
      msk = !gw ? 4'hF : (!bwe ? ~lw : 4'h0);
      wr  = act && (kind != K_P) && (msk != 4'h0);
      ea  = {m_up, m_ilv ? (m_base ^ m_cnt) : (m_base + m_cnt)};
      if (wr) begin
         for (int i = 0; i < 4; i++)
            if (msk[i]) mdl[ea][i*9 +: 9] = d[i*9 +: 9];
      end
      @(negedge clk);
      check(p_tag, {dq_drv, dq_out}, {p_drv, p_drv ? p_data : '0});
      p_drv  = act && !wr && !oe_n;
      p_data = mdl[ea];
      p_tag  = tag;
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset", {dq_drv, dq_out}, {1'b0, 36'h0});
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle", {dq_drv, dq_out}, {1'b0, 36'h0});

      // R6: fill every word with a global write (write cycles must not drive)
      for (int a = 0; a < 256; a++)
         issue(K_C, 1'b0, a, 1'b0, 1'b1, 4'hF, pat(a), 1'b0, "R6 fill");

      // R1 R4 R5 R8: burst reads in both orders from every start offset
      for (int m = 0; m < 2; m++)
         for (int b = 0; b < 4; b++)
            for (int u = 0; u < 64; u += 21) begin
               issue(K_P, 1'b0, u*4 + b, 1'b1, 1'b1, 4'hF, '0, 1'(m), "R1 R8 load");
               for (int n = 0; n < 4; n++)
                  issue(K_A, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0,
                        m == 1 ? "R5 interleaved beat" : "R4 linear beat");
            end

      // R3: controller-strobe read, then hold and step
      issue(K_C, 1'b0, 8'h33, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R1 ctrl read");
      issue(K_S, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R3 hold");
      issue(K_S, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R3 hold");
      issue(K_A, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R3 step");

      // R7: every lane combination, read back merged word
      for (int k = 0; k < 16; k++) begin
         issue(K_C, 1'b0, 8'h40 + k, 1'b1, 1'b0, ~4'(k), ~pat(k), 1'b0, "R7 byte write");
         issue(K_C, 1'b0, 8'h40 + k, 1'b1, 1'b0, 4'hF, '0, 1'b0, "R7 readback");
      end
      // R7: lane strobes without byte enable give a read
      issue(K_C, 1'b0, 8'h50, 1'b1, 1'b1, 4'h0, 36'h0, 1'b0, "R7 no enable");

      // R6: burst write with global write, then interleaved read back
      issue(K_C, 1'b0, 8'h82, 1'b0, 1'b1, 4'hF, 36'h1_1111_1111, 1'b1, "R6 burst write");
      for (int n = 1; n < 4; n++)
         issue(K_A, 1'b0, 0, 1'b0, 1'b0, 4'h5, 36'h1_1111_1111 * n, 1'b0, "R6 burst write");
      issue(K_P, 1'b0, 8'h82, 1'b1, 1'b1, 4'hF, '0, 1'b1, "R6 readback");
      for (int n = 0; n < 4; n++)
         issue(K_A, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R6 readback");

      // R2: processor strobe with write qualifiers is a read, memory unchanged
      issue(K_P, 1'b0, 8'h90, 1'b0, 1'b0, 4'h0, 36'hF_FFFF_FFFF, 1'b0, "R2 proc read");
      issue(K_C, 1'b0, 8'h90, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R2 unchanged");

      // R10: deselect through the chip enable
      issue(K_C, 1'b0, 8'h10, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R10 before");
      issue(K_P, 1'b1, 8'h11, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R10 desel");
      issue(K_A, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R10 adv idle");
      issue(K_S, 1'b0, 0, 1'b0, 1'b1, 4'hF, 36'h0, 1'b0, "R10 idle no write");
      issue(K_C, 1'b0, 8'h11, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R10 reselect");

      // R9: asynchronous output enable
      issue(K_P, 1'b0, 8'h20, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R8 read");
      issue(K_S, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R8 hold");
      oe_n = 1'b1;
      #0.5;
      check("R9 oe off", {dq_drv, dq_out}, {1'b0, 36'h0});
      oe_n = 1'b0;
      #0.5;
      check("R9 oe on", {dq_drv, dq_out}, {1'b1, mdl[8'h20]});
      issue(K_S, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R3 flush");
      issue(K_S, 1'b0, 0, 1'b1, 1'b1, 4'hF, '0, 1'b0, "R3 flush");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule